// File: doc/BRIEF.md
# I2C SCL Phase Divider

This block turns a fast peripheral clock into the serial clock waveform of an I2C master. A 32-bit divider word carries two independent 16-bit divisors, one for the low half and one for the high half of SCL. Each half is split into eight equal sub-phases. A tick marks the last clock of every sub-phase, and the bit engine uses these ticks to place SDA changes and samples.

While the run enable is deasserted, SCL stays released (high) and every counter rests at zero. When the run enable is asserted, the clock starts with a fresh low half. The low and high halves then alternate until the enable drops. Divider updates are captured only when a new full period begins, so a period that has started always completes with the split it began with. Detection of clock stretching and bus arbitration belong elsewhere.

Top module: `scl_phase_divider`

## Requirements
- R1: While `run_en` is low (and after reset), `scl_o` is 1 and `phase_tick`, `scl_rise` and `scl_fall` are 0.
- R2: Assume `run_en` is sampled high at a clock edge while the block is idle. In the cycle after that edge, `scl_o` is 0 and `scl_fall` is 1. Every period begins with its low half.
- R3: The low divisor sits in `div_cfg[15:0]`. A low half lasts 8*(low+1) clocks.
- R4: The high divisor sits in `div_cfg[31:16]`. A high half lasts 8*(high+1) clocks, so a full period is 8*(low+1+high+1) clocks.
- R5: `phase_tick` is 1 in the last cycle of every run of (d+1) clocks inside a half, where d is the divisor of that half. This gives exactly 8 ticks per half.
- R6: `scl_rise` is 1 only in the first cycle that `scl_o` is 1 after being 0. `scl_fall` is 1 only in the first cycle that `scl_o` is 0 after being 1. Each strobe lasts one cycle.
- R7: A new `div_cfg` value has no effect on the current period. It takes effect at the first cycle of the next full period.
- R8: Assume `run_en` drops. One edge later the block is idle, with `scl_o` at 1; if SCL was low, `scl_rise` is 1 in that cycle. A later restart begins from zeroed counters with a full low half.
- R9: Any split of the two fields is accepted, including 0 and values up to 65535. With a divisor of 65535, the first tick of the half comes 65536 clocks after its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 32 | High divisor in [31:16], low divisor in [15:0] |
| run_en | input | 1 | Run enable; low holds SCL released |
| scl_o | output | 1 | SCL level (1 = released) |
| phase_tick | output | 1 | Last cycle of each sub-phase |
| scl_rise | output | 1 | First cycle of a high SCL level |
| scl_fall | output | 1 | First cycle of a low SCL level |

## Verification
All outputs decode registered state, so each result is due in the cycle that follows the clock edge that changed the state. The first low cycle and its fall strobe follow the edge that samples `run_en`. A tick is visible during the final clock of its sub-phase. A divider change appears in the first cycle after the period wrap. The bench drives inputs on the falling clock edge and samples on the next falling edge. It tracks a cycle index since start and computes the expected level, tick and strobes from the divisors latched at each wrap, using the value present at the edge just before that sample.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  // clocks spent in one SCL half for a given divisor
  function automatic int unsigned half_cycles(input int unsigned div,
                                              input int unsigned sub_ph);
    return sub_ph * (div + 1);
  endfunction

endpackage

// File: rtl/scl_div_prescale.sv
module scl_div_prescale #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = !clear && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/scl_div_phase_seq.sv
module scl_div_phase_seq
  import scl_div_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SUB_PH = 8,
  localparam int unsigned SUB_W = $clog2(SUB_PH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_lo,
  input  logic [DIV_W-1:0] cfg_hi,
  input  logic             tick,
  output logic             running,
  output scl_phase_e       phase,
  output logic [DIV_W-1:0] lo_act,
  output logic [DIV_W-1:0] hi_act,
  output logic [DIV_W-1:0] limit,
  output logic [SUB_W-1:0] sub_idx,
  output logic             half_done,
  output logic             period_wrap
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_PH - 1);

  assign limit       = (phase == PH_HIGH) ? hi_act : lo_act;
  assign half_done   = tick && (sub_idx == SUB_LAST);
  assign period_wrap = half_done && (phase == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_LOW;
      sub_idx <= '0;
      lo_act  <= '0;
      hi_act  <= '0;
    end else if (!run) begin
      running <= 1'b0;
      phase   <= PH_LOW;
      sub_idx <= '0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= PH_LOW;
      sub_idx <= '0;
      lo_act  <= cfg_lo;
      hi_act  <= cfg_hi;
    end else if (tick) begin
      if (half_done) begin
        sub_idx <= '0;
        if (phase == PH_HIGH) begin
          phase  <= PH_LOW;
          lo_act <= cfg_lo;
          hi_act <= cfg_hi;
        end else begin
          phase <= PH_HIGH;
        end
      end else begin
        sub_idx <= sub_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_div_edge.sv
module scl_div_edge
  import scl_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  scl_phase_e phase,
  output logic       scl,
  output logic       rise,
  output logic       fall
);

  logic scl_q;

  assign scl  = !running || (phase == PH_HIGH);
  assign rise = scl && !scl_q;
  assign fall = !scl && scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl;
  end

endmodule

// File: rtl/scl_phase_divider.sv
module scl_phase_divider
  import scl_div_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SUB_PH = 8,
  localparam int unsigned CFG_W = 2 * DIV_W,
  localparam int unsigned SUB_W = $clog2(SUB_PH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] div_cfg,
  input  logic             run_en,
  output logic             scl_o,
  output logic             phase_tick,
  output logic             scl_rise,
  output logic             scl_fall
);

  logic [DIV_W-1:0] cfg_lo, cfg_hi;
  logic [DIV_W-1:0] lo_act, hi_act, cur_limit;
  logic [SUB_W-1:0] sub_idx;
  logic             act_running, tick, half_done, period_wrap;
  scl_phase_e       cur_phase;

  assign cfg_lo = div_cfg[DIV_W-1:0];
  assign cfg_hi = div_cfg[CFG_W-1:DIV_W];

  scl_div_prescale #(.W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!act_running),
    .limit (cur_limit),
    .tick  (tick)
  );

  scl_div_phase_seq #(.DIV_W(DIV_W), .SUB_PH(SUB_PH)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_en),
    .cfg_lo      (cfg_lo),
    .cfg_hi      (cfg_hi),
    .tick        (tick),
    .running     (act_running),
    .phase       (cur_phase),
    .lo_act      (lo_act),
    .hi_act      (hi_act),
    .limit       (cur_limit),
    .sub_idx     (sub_idx),
    .half_done   (half_done),
    .period_wrap (period_wrap)
  );

  scl_div_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (act_running),
    .phase   (cur_phase),
    .scl     (scl_o),
    .rise    (scl_rise),
    .fall    (scl_fall)
  );

  assign phase_tick = tick;

endmodule

// File: rtl/scl_div_checker.sv
module scl_div_checker
  import scl_div_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SUB_PH = 8,
  localparam int unsigned SUB_W = $clog2(SUB_PH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             scl_o,
  input logic             phase_tick,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             act_running,
  input scl_phase_e       cur_phase,
  input logic [DIV_W-1:0] lo_act,
  input logic [DIV_W-1:0] hi_act,
  input logic [SUB_W-1:0] sub_idx,
  input logic             half_done,
  input logic             period_wrap
);

  logic [31:0] seg_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         seg_cnt <= '0;
    else if (!act_running || half_done) seg_cnt <= '0;
    else                                seg_cnt <= seg_cnt + 32'd1;
  end

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (scl_o && !phase_tick && !scl_fall));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_running) |-> (!scl_o && scl_fall));

  a_r3_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && cur_phase == PH_LOW) |->
      (seg_cnt + 32'd1 == half_cycles(32'(lo_act), SUB_PH)));

  a_r4_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && cur_phase == PH_HIGH) |->
      (seg_cnt + 32'd1 == half_cycles(32'(hi_act), SUB_PH)));

  a_r5_sub_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && run_en) |=> (sub_idx == '0));

  a_r5_tick_running: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> act_running);

  a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);

  a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall);

  a_r6_strobe_level: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise |-> scl_o) and (scl_fall |-> !scl_o));

  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (act_running && !period_wrap) |=> ($stable(lo_act) && $stable(hi_act)));

endmodule

bind scl_phase_divider scl_div_checker #(.DIV_W(DIV_W), .SUB_PH(SUB_PH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .scl_o       (scl_o),
  .phase_tick  (phase_tick),
  .scl_rise    (scl_rise),
  .scl_fall    (scl_fall),
  .act_running (act_running),
  .cur_phase   (cur_phase),
  .lo_act      (lo_act),
  .hi_act      (hi_act),
  .sub_idx     (sub_idx),
  .half_done   (half_done),
  .period_wrap (period_wrap)
);

// File: tb/scl_phase_divider_tb.sv
module scl_phase_divider_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'd0;
  logic        run = 1'b0;
  logic        scl, tick, rise, fall;

  int n_run = 0;
  int n_fail = 0;

  // model state
  int  tin, lo_m, hi_m;
  bit  fresh;

  always #10 clk = ~clk;

  scl_phase_divider u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_cfg    (cfg),
    .run_en     (run),
    .scl_o      (scl),
    .phase_tick (tick),
    .scl_rise   (rise),
    .scl_fall   (fall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag, input int exp_rise);
    @(negedge clk);
    chk({tag, " scl"},  int'(scl),  1);
    chk({tag, " tick"}, int'(tick), 0);
    chk({tag, " rise"}, int'(rise), exp_rise);
    chk({tag, " fall"}, int'(fall), 0);
  endtask

  // one running cycle against the arithmetic model
  task automatic step();
    int len_lo, period, off, d;
    bit e_scl;
    @(negedge clk);
    if (fresh) begin
      fresh = 1'b0;
      tin = 0;
      lo_m = int'(cfg[15:0]);
      hi_m = int'(cfg[31:16]);
    end else begin
      tin++;
      if (tin == 8 * (lo_m + 1) + 8 * (hi_m + 1)) begin
        tin = 0;
        lo_m = int'(cfg[15:0]);  // R7: latched at period start
        hi_m = int'(cfg[31:16]);
      end
    end
    len_lo = 8 * (lo_m + 1);
    period = len_lo + 8 * (hi_m + 1);
    e_scl  = (tin >= len_lo);
    off    = e_scl ? tin - len_lo : tin;
    d      = e_scl ? hi_m : lo_m;
    chk("R3/R4 scl level", int'(scl), int'(e_scl));
    chk("R5 phase tick", int'(tick), int'((off % (d + 1)) == d));
    chk("R6 rise strobe", int'(rise), int'(tin == len_lo));
    chk("R2/R6 fall strobe", int'(fall), int'(tin == 0));
    if (period < 0) chk("R4 period", period, 0);
  endtask

  task automatic start(input logic [15:0] hi, input logic [15:0] lo);
    @(negedge clk);
    cfg = {hi, lo};
    run = 1'b1;
    fresh = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset and idle
    repeat (3) @(negedge clk);
    chk("R1 scl in reset", int'(scl), 1);
    rst_n = 1'b1;
    repeat (3) chk_idle("R1 idle", 0);

    // R3 R4 R5 R6: sweep of small splits, two periods each, then stop
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        start(16'(hi), 16'(lo));
        for (int k = 0; k < 2 * 8 * (lo + hi + 2); k++) step();
        run = 1'b0;               // last sample was high, no edge
        repeat (2) chk_idle("R8 stop after high", 0);
      end
    end

    // R7: change divider mid-period
    start(16'd1, 16'd2);
    repeat (5) step();
    cfg = {16'd3, 16'd0};
    for (int k = 0; k < 150; k++) step();
    run = 1'b0;
    @(negedge clk);
    run = 1'b0;

    // R8: drop while low, then fresh restart
    repeat (2) @(negedge clk);
    start(16'd3, 16'd3);
    repeat (10) step();
    run = 1'b0;
    chk_idle("R8 stop during low", 1);
    chk_idle("R8 idle after stop", 0);
    start(16'd2, 16'd1);
    for (int k = 0; k < 60; k++) step();
    run = 1'b0;
    chk_idle("R8 stop", int'(!scl));

    // R9: asymmetric and wide divisors
    start(16'd300, 16'd0);
    for (int k = 0; k < 2500; k++) step();
    run = 1'b0;
    @(negedge clk);
    start(16'd0, 16'd65535);
    for (int k = 0; k < 66000; k++) step();
    run = 1'b0;
    chk_idle("R9 stop", 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule